// File: doc/BRIEF.md
# Synthesizer Serial Register Writer

This block turns one register command into a complete serial transaction towards a direct digital synthesizer. A command carries a read/write flag, a 5-bit register address, a 32-bit data word and a request for an update strobe. It is offered on a valid/ready handshake. The block builds an 8-bit instruction, then clocks out exactly as many data bits as the addressed register holds, so the synthesizer never stays half-filled. The link is four wires: an active-low select, a serial clock that idles low, a data output and a data input.

The serial clock runs at the system clock divided by an even parameter `CLK_DIV`. Data changes when the serial clock rises and is valid while the clock is falling. The `lsb_first` input chooses the shift direction for the whole frame and is captured when the command is accepted. When a read is issued, the bits on `sdi` are collected and returned right-aligned. When an update is requested, a strobe of `UPD_CYCLES` system clocks follows the frame, to commit the buffered registers.

Top module: `dds_serial_writer`

## Requirements
- R1: Out of reset and whenever no frame is running, `cs_n` is 1, `sclk` is 0 and `io_update` is 0; `sclk` is never high while `cs_n` is high.
- R2: The serial clock is high for `CLK_DIV/2` system cycles and low for `CLK_DIV/2` system cycles per bit. `sdo` changes only at rising serial clock edges and is stable while `sclk` is high.
- R3: A frame starts with an instruction byte whose bit 7 is the read flag (1 = read, 0 = write), whose bits 6:5 are 0 and whose bits 4:0 are the address. The data bits follow from `cmd_data`, counted from bit 0 up to the register width.
- R4: The data phase length follows the address: 0x00 gives 8 bits, 0x01 gives 24, 0x02 gives 16 and 0x04 gives 32. A frame therefore has 8 plus that many serial clock pulses, and `cmd_data` bits above the width are never sent.
- R5: With `lsb_first` = 0, the instruction and the data go out most significant bit first; with 1, least significant bit first. The value is taken at acceptance, and later changes do not affect the running frame.
- R6: When `cmd_update` was 1, `io_update` rises in the same cycle that `cs_n` returns high and stays high for exactly `UPD_CYCLES` system cycles.
- R7: A command for any other address is rejected: `err` is high for one cycle, in the cycle after acceptance. `cs_n` stays high and `busy` stays low.
- R8: `cmd_ready` equals not `busy`. `busy` is high from the cycle after acceptance until `cs_n` rises, or until `io_update` falls when an update was requested.
- R9: `done` is a single-cycle pulse in the first cycle in which `busy` is low again. That is `CLK_DIV/2 + CLK_DIV*(8+len)` cycles after the accepting edge, plus `UPD_CYCLES` with an update.
- R10: For a read, `sdi` is sampled at each falling serial clock edge of the data phase. `rd_data` then holds the `len`-bit value right-aligned, with zeros above it. The first bit received is the most significant bit when `lsb_first` was 0 and the least significant bit when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 5 | Register address |
| cmd_data | input | 32 | Data to send, right-aligned |
| cmd_update | input | 1 | Issue an update strobe after the frame |
| lsb_first | input | 1 | Bit order for the frame |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an unknown address |
| rd_data | output | 32 | Data captured by the last read |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the synthesizer |
| sdi | input | 1 | Serial data from the synthesizer |
| io_update | output | 1 | Update strobe |

## Verification
`busy` is due one cycle after the accepting edge and `err` in that same cycle. The first rising serial clock comes `CLK_DIV/2` cycles after acceptance. `done` comes `CLK_DIV/2 + CLK_DIV*(8+len)` cycles after acceptance, plus `UPD_CYCLES` when an update is requested. The bench samples on the falling system clock edge and counts those cycles exactly from the accepting edge. A monitor decodes frames edge by edge, so it does not rely on absolute times. It checks every serial clock phase width as it happens and takes `sdo` at the sample where `sclk` has just fallen. It then compares the whole frame, including the update strobe's start and width, against the scoreboard entry that the driver queued.

// File: rtl/dds_ser_pkg.sv
package dds_ser_pkg;

  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int INSTR_W = 8;
  localparam int FRAME_W = INSTR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_UPD
  } ser_state_t;

  // register width in bits for an address, 0 when unknown
  function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
    case (a)
      5'h00:   return CNT_W'(8);
      5'h01:   return CNT_W'(24);
      5'h02:   return CNT_W'(16);
      5'h04:   return CNT_W'(32);
      default: return '0;
    endcase
  endfunction

  function automatic logic [INSTR_W-1:0] make_instr(input logic rd,
                                                     input logic [ADDR_W-1:0] a);
    return {rd, 2'b00, a};
  endfunction

  function automatic logic [INSTR_W-1:0] rev_instr(input logic [INSTR_W-1:0] v);
    logic [INSTR_W-1:0] r;
    for (int i = 0; i < INSTR_W; i++) r[i] = v[INSTR_W-1-i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] rev_data(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  // left-aligned frame: bit FRAME_W-1 leaves first
  function automatic logic [FRAME_W-1:0] build_frame(input logic [INSTR_W-1:0] ins,
                                                      input logic [DATA_W-1:0] d,
                                                      input logic [CNT_W-1:0] len,
                                                      input logic lsb);
    logic [CNT_W-1:0] pad;
    pad = CNT_W'(DATA_W) - len;
    if (lsb) return {rev_instr(ins), rev_data(d)};
    return {ins, d << pad};
  endfunction

  // right-align a captured word
  function automatic logic [DATA_W-1:0] align_rx(input logic [DATA_W-1:0] rx,
                                                  input logic [CNT_W-1:0] len,
                                                  input logic lsb);
    logic [CNT_W-1:0] pad;
    pad = CNT_W'(DATA_W) - len;
    if (lsb) return rx >> pad;
    return rx;
  endfunction

endpackage

// File: rtl/dds_half_tick.sv
module dds_half_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (HALF <= 1) begin : g_direct
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/dds_upd_pulse.sv
module dds_upd_pulse #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse,
  output logic last
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          on;

  assign pulse = on;
  assign last  = on && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on  <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      on  <= 1'b1;
      cnt <= '0;
    end else if (on) begin
      if (last) on <= 1'b0;
      else      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dds_serial_writer.sv
module dds_serial_writer
  import dds_ser_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int UPD_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_addr,
  input  logic [31:0] cmd_data,
  input  logic        cmd_update,
  input  logic        lsb_first,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] rd_data,
  output logic        cs_n,
  output logic        sclk,
  output logic        sdo,
  input  logic        sdi,
  output logic        io_update
);

  localparam int HALF = CLK_DIV / 2;

  ser_state_t         state;
  logic               cs_q, sclk_q, sdo_q;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   sent, total_q, len_q;
  logic               rd_q, lsb_q, upd_q;
  logic [DATA_W-1:0]  rx, rd_q_data;
  logic               done_q, err_q;

  // named events, also used by the checker
  logic             tick, accept, go, bad;
  logic             rise_ev, fall_ev, end_ev, cap_ev, frame_last;
  logic             upd_start, upd_last, upd_on;
  logic [CNT_W-1:0] len_in;
  logic [CNT_W-1:0] total_bits;

  assign len_in     = reg_len(cmd_addr);
  assign accept     = cmd_valid && (state == ST_IDLE);
  assign go         = accept && (len_in != '0);
  assign bad        = accept && (len_in == '0);
  assign frame_last = (sent == total_q);
  assign rise_ev    = tick && ((state == ST_LEAD) ||
                               (state == ST_SHIFT && !sclk_q && !frame_last));
  assign fall_ev    = tick && (state == ST_SHIFT) && sclk_q;
  assign end_ev     = tick && (state == ST_SHIFT) && !sclk_q && frame_last;
  assign cap_ev     = fall_ev && rd_q && (sent >= CNT_W'(INSTR_W));
  assign upd_start  = end_ev && upd_q;
  assign total_bits = total_q;

  dds_half_tick #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state == ST_LEAD) || (state == ST_SHIFT)),
    .tick (tick)
  );

  dds_upd_pulse #(.CYCLES(UPD_CYCLES)) u_upd (
    .clk  (clk),
    .rst_n(rst_n),
    .start(upd_start),
    .pulse(upd_on),
    .last (upd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b0;
      sdo_q     <= 1'b0;
      sr        <= '0;
      sent      <= '0;
      total_q   <= '0;
      len_q     <= '0;
      rd_q      <= 1'b0;
      lsb_q     <= 1'b0;
      upd_q     <= 1'b0;
      rx        <= '0;
      rd_q_data <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= bad;
      case (state)
        ST_IDLE: begin
          if (go) begin
            state   <= ST_LEAD;
            cs_q    <= 1'b0;
            sr      <= build_frame(make_instr(cmd_read, cmd_addr), cmd_data,
                                   len_in, lsb_first);
            sent    <= '0;
            total_q <= CNT_W'(INSTR_W) + len_in;
            len_q   <= len_in;
            rd_q    <= cmd_read;
            lsb_q   <= lsb_first;
            upd_q   <= cmd_update;
            rx      <= '0;
          end
        end
        ST_LEAD, ST_SHIFT: begin
          if (fall_ev) begin
            sclk_q <= 1'b0;
            sent   <= sent + 1'b1;
            if (cap_ev)
              rx <= lsb_q ? {sdi, rx[DATA_W-1:1]} : {rx[DATA_W-2:0], sdi};
          end else if (rise_ev) begin
            state  <= ST_SHIFT;
            sclk_q <= 1'b1;
            sdo_q  <= sr[FRAME_W-1];
            sr     <= sr << 1;
          end else if (end_ev) begin
            cs_q  <= 1'b1;
            sdo_q <= 1'b0;
            if (rd_q) rd_q_data <= align_rx(rx, len_q, lsb_q);
            if (upd_q) state <= ST_UPD;
            else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        ST_UPD: begin
          if (upd_last) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_data   = rd_q_data;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign sdo       = sdo_q;
  assign io_update = upd_on;

endmodule

// File: rtl/dds_serial_writer_chk.sv
module dds_serial_writer_chk #(
  parameter int UPD_CYCLES = 4,
  parameter int CW         = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          sdo,
  input logic          io_update,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [CW-1:0] frame_bits
);

  localparam int UW = $clog2(UPD_CYCLES + 2);

  logic          sclk_d;
  logic [CW-1:0] rise_cnt;
  logic [UW-1:0] upd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      upd_cnt  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (!io_update) upd_cnt <= '0;
      else            upd_cnt <= upd_cnt + 1'b1;
    end
  end

  a_r1_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r2_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  a_r4_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == frame_bits));

  a_r6_upd_starts_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_update) |-> $rose(cs_n));

  a_r6_upd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_update) |-> (upd_cnt == UW'(UPD_CYCLES)));

  a_r7_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy));

  a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n || io_update) |-> busy);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind dds_serial_writer dds_serial_writer_chk #(
  .UPD_CYCLES(UPD_CYCLES),
  .CW        (dds_ser_pkg::CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .sdo       (sdo),
  .io_update (io_update),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .frame_bits(total_bits)
);

// File: tb/tb_dds_serial_writer.sv
`timescale 1ns/1ps
module tb_dds_serial_writer;

  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int UPD     = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_read, cmd_update, lsb_first, sdi;
  logic [4:0]  cmd_addr;
  logic [31:0] cmd_data;
  logic        cmd_ready, busy, done, err, cs_n, sclk, sdo, io_update;
  logic [31:0] rd_data;

  always #10 clk = ~clk;

  dds_serial_writer #(.CLK_DIV(CLK_DIV), .UPD_CYCLES(UPD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_update(cmd_update), .lsb_first(lsb_first), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
    .sdi(sdi), .io_update(io_update)
  );

  typedef struct {
    int          n;
    logic [39:0] bits;
    bit          upd;
    bit          rd;
    bit          lsb;
    int          len;
    logic [31:0] pat;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nerr = 0;
  bit   reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
    $finish;
  endtask

  // register width table restated from R4
  function automatic int width_of(input logic [4:0] a);
    if (a == 5'h00) return 8;
    if (a == 5'h01) return 24;
    if (a == 5'h02) return 16;
    if (a == 5'h04) return 32;
    return 0;
  endfunction

  // driver: queue the expected frame, then issue the command
  task automatic do_cmd(input bit rd, input logic [4:0] a, input logic [31:0] d,
                        input bit upd, input bit lsb, input logic [31:0] pat,
                        input bit flip);
    int          len;
    int          cyc;
    exp_t        e;
    logic [7:0]  ins;
    logic [31:0] mask;
    len = width_of(a);
    ins = {rd, 2'b00, a};
    if (len > 0) begin
      e.n = 8 + len; e.bits = '0; e.upd = upd; e.rd = rd;
      e.lsb = lsb; e.len = len; e.pat = pat;
      for (int i = 0; i < 8; i++)   e.bits[i] = lsb ? ins[i] : ins[7-i];
      for (int k = 0; k < len; k++) e.bits[8+k] = lsb ? d[k] : d[len-1-k];
      q.push_back(e);
    end
    @(negedge clk);
    cmd_valid = 1; cmd_read = rd; cmd_addr = a; cmd_data = d;
    cmd_update = upd; lsb_first = lsb;
    @(negedge clk);
    cmd_valid = 0;
    if (flip) lsb_first = !lsb;
    if (len == 0) begin
      chk(err == 1'b1, "R7", "err after bad address", err, 1);
      chk(busy == 1'b0 && cs_n == 1'b1, "R7", "no frame for bad address", {busy, cs_n}, 2'b01);
      @(negedge clk);
      chk(err == 1'b0, "R7", "err one cycle", err, 0);
      chk(cs_n == 1'b1 && cmd_ready == 1'b1, "R7", "still idle", {cs_n, cmd_ready}, 2'b11);
      return;
    end
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R8", "busy after accept", {busy, cmd_ready}, 2'b10);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      if (!done) chk(busy == 1'b1, "R8", "busy until finish", busy, 1);
    end
    chk(cyc == HALF + CLK_DIV * (8 + len) + (upd ? UPD : 0), "R9", "done latency",
        cyc, HALF + CLK_DIV * (8 + len) + (upd ? UPD : 0));
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R8", "free at done", {busy, cmd_ready}, 2'b01);
    chk(cs_n == 1'b1 && sclk == 1'b0 && io_update == 1'b0, "R1", "idle lines at done",
        {cs_n, sclk, io_update}, 3'b100);
    if (rd) begin
      mask = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
      chk(rd_data == (pat & mask), "R10", "read data", rd_data, pat & mask);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
    lsb_first = 0;
  endtask

  // monitor: decode frames and compare with the scoreboard
  initial begin : monitor
    bit          ps, pcs, pupd, psdo;
    int          nb, rises, hcnt, lcnt, ucnt, k;
    logic [39:0] got, mask;
    exp_t        cur;
    ps = 0; pcs = 1; pupd = 0; psdo = 0;
    nb = 0; rises = 0; hcnt = 0; lcnt = 0; ucnt = 0; got = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (pcs && !cs_n) begin
        nb = 0; rises = 0; got = '0; lcnt = 0;
      end
      if (!ps && sclk) begin
        rises++;
        if (nb > 0) chk(lcnt == HALF, "R2", "sclk low width", lcnt, HALF);
        lcnt = 0; hcnt = 0;
        if (q.size() > 0 && q[0].rd && rises > 8) begin
          k = rises - 9;
          sdi = q[0].lsb ? q[0].pat[k] : q[0].pat[q[0].len-1-k];
        end
      end
      if (ps && sclk) chk(sdo == psdo, "R2", "sdo stable while sclk high", sdo, psdo);
      if (ps && !sclk) begin
        chk(hcnt == HALF, "R2", "sclk high width", hcnt, HALF);
        if (nb < 40) got[nb] = sdo;
        nb++;
      end
      if (sclk) hcnt++;
      else if (!cs_n) lcnt++;
      if (!pcs && cs_n) begin
        sdi = 0;
        if (q.size() == 0) chk(0, "R3", "unexpected frame", nb, 0);
        else begin
          cur = q.pop_front();
          chk(nb == cur.n, "R4", "pulses per frame", nb, cur.n);
          chk(((got ^ cur.bits) & 40'hFF) == 0, "R3", "instruction byte", got[7:0], cur.bits[7:0]);
          mask = (cur.n >= 40) ? {40{1'b1}} : ((40'h1 << cur.n) - 1);
          chk(((got ^ cur.bits) & mask) == 0, "R5", "frame bit order", got, cur.bits);
          chk(io_update == cur.upd, "R6", "update starts with deselect", io_update, cur.upd);
        end
      end
      if (pupd && !io_update) begin
        chk(ucnt == UPD, "R6", "update width", ucnt, UPD);
        ucnt = 0;
      end
      if (io_update) ucnt++;
      ps = sclk; pcs = cs_n; pupd = io_update; psdo = sdo;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin : main
    rst_n = 0; cmd_valid = 0; cmd_read = 0; cmd_addr = '0; cmd_data = '0;
    cmd_update = 0; lsb_first = 0; sdi = 0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && io_update == 1'b0, "R1", "reset lines",
        {cs_n, sclk, io_update}, 3'b100);
    chk(busy == 1'b0 && cmd_ready == 1'b1 && done == 1'b0 && err == 1'b0, "R8",
        "reset handshake", {busy, cmd_ready, done, err}, 4'b0100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_cmd(0, 5'h00, 32'hFFFF_FF01, 0, 0, '0, 0); // R4 upper bits unused
    do_cmd(0, 5'h01, 32'h00A5_C3F0, 1, 1, '0, 0); // R5 lsb, R6 update
    do_cmd(0, 5'h02, 32'h0000_1234, 1, 0, '0, 0);
    do_cmd(0, 5'h04, 32'h8000_0001, 0, 1, '0, 1); // R5 lsb_first flips mid frame
    do_cmd(0, 5'h04, 32'h3333_3333, 1, 0, '0, 1);
    do_cmd(1, 5'h04, 32'h0,          0, 0, 32'hDEAD_BEEF, 0); // R10 msb read
    do_cmd(1, 5'h01, 32'h0,          0, 1, 32'h005A_0F3C, 0); // R10 lsb read
    do_cmd(1, 5'h02, 32'h0,          1, 0, 32'h0000_C001, 0);
    do_cmd(0, 5'h03, 32'h1,          1, 0, '0, 0); // R7
    do_cmd(1, 5'h1F, 32'h1,          0, 1, '0, 0); // R7
    do_cmd(0, 5'h00, 32'h0000_0080, 0, 1, '0, 0);
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R3", "all frames seen", q.size(), 0);
    report();
  end

endmodule